// File: doc/BRIEF.md
# Channel-Level Time Slot Interchange

This block is a unidirectional, non-blocking time slot interchange for bit-serial time-division streams. Each of the `NSTREAM` input lines carries a frame of `NCHAN` byte-wide channels, most significant bit first. One clock is one bit. Each received byte goes into a three-frame data store. The write address follows the arrival order: frame, stream, then channel. On the output side, each outgoing channel position has a map entry that names the source stream and channel whose byte it carries. Because of this, any source can feed any number of outputs.

The map can be rewritten at any time through a plain synchronous write port, one entry per cycle, without disturbing the other channels. The delay through the switch is fixed at two frames for every pairing. The outgoing frames use exactly the bit positions of the incoming frames, so both sides share the one frame sync input. At 32 streams of 512 channels, a map entry is 14 bits wide: 5 bits of stream and 9 bits of channel.

Top module: `tsi_switch`

## Requirements
- R1: `ser_out` is all zero while reset is held, before the first `frame_sync` and during the first two whole frames after the first `frame_sync` following each reset.
- R2: The cycle in which `frame_sync` is high carries the most significant bit of channel 0. Channel c occupies the eight cycles that start 8·c cycles after that, most significant bit first. This holds on every `ser_in` and `ser_out` line, with the same positions on both sides.
- R3: A map address names an output slot and a map entry names a source slot. Both use the same format: stream number in the upper log2(NSTREAM) bits and channel number in the lower log2(NCHAN) bits.
- R4: From the third frame after sync onward, output slot (s,c) of frame F carries the byte received in frame F−2 on the source slot held in map entry (s,c).
- R5: After reset, every map entry points each output slot at the input slot with the same stream and channel.
- R6: When several map entries name one source slot, every one of those output slots carries that source's byte.
- R7: A write with `map_we` high updates the addressed entry at that clock edge. Entry (s,c) is read in the last bit cycle before channel c starts (for channel 0, the last cycle of the previous frame). A write made early in a frame therefore changes channels 1 and up in that frame, and channel 0 from the next frame. No other entry changes.
- R8: The two-frame delay holds whether the source channel comes before or after its destination channel within the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one stream bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | High in the first bit cycle of each frame |
| ser_in | input | NSTREAM | Incoming serial streams |
| ser_out | output | NSTREAM | Outgoing serial streams |
| map_we | input | 1 | Map entry write strobe |
| map_addr | input | log2(NSTREAM)+log2(NCHAN) | Output slot whose entry is written |
| map_wdata | input | log2(NSTREAM)+log2(NCHAN) | Source slot for that output |

## Verification
The assertions assume that, once the first sync has been seen, `frame_sync` arrives exactly every 8·NCHAN cycles; the frame counter assertion flags any departure from that. Both parameters are assumed to be powers of two, at least 2. The bench asserts `frame_sync` only in the first cycle of each frame it drives, and it issues map writes only from the third to the sixth cycle of a frame. It also holds `frame_sync` low between reset and the first frame, so the output is checked both before and after the sync lock.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  // three frames of data storage rotate: write, hold, read
  localparam int NBANK = 3;
  typedef logic [1:0] bank_t;

  function automatic bank_t bank_next(bank_t b);
    return (b == bank_t'(NBANK - 1)) ? bank_t'(0) : b + bank_t'(1);
  endfunction

  // bank holding the frame two frames older than the one being written,
  // optionally for the frame that starts after the current one
  function automatic bank_t read_bank(bank_t wr, logic for_next_frame);
    return for_next_frame ? bank_next(bank_next(wr)) : bank_next(wr);
  endfunction

  // frames seen since sync, saturating at two
  function automatic logic [1:0] age_step(logic [1:0] a);
    return (a == 2'd2) ? a : a + 2'd1;
  endfunction
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer
  import tsi_pkg::*;
#(
  parameter int NCHAN = 8,
  localparam int CW = $clog2(NCHAN),
  localparam int POSW = CW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_sync,
  output logic          active,
  output logic [CW-1:0] cur_chan,
  output logic [2:0]    cur_bit,
  output bank_t         cur_bank,
  output logic [1:0]    cur_age
);
  logic [POSW-1:0] pos_q, cur_pos;
  logic            locked_q;
  bank_t           bank_q;
  logic [1:0]      age_q;
  logic            frame_end;

  always_comb begin
    cur_pos   = frame_sync ? '0 : pos_q;
    active    = locked_q | frame_sync;
    cur_bank  = locked_q ? bank_q : bank_t'(0);
    cur_age   = locked_q ? age_q : 2'd0;
    cur_bit   = cur_pos[2:0];
    cur_chan  = cur_pos[POSW-1:3];
    frame_end = active && (&cur_pos);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q    <= '0;
      locked_q <= 1'b0;
      bank_q   <= bank_t'(0);
      age_q    <= 2'd0;
    end else begin
      pos_q <= cur_pos + POSW'(1);
      if (frame_sync) locked_q <= 1'b1;
      if (frame_end) begin
        bank_q <= bank_next(cur_bank);
        age_q  <= age_step(cur_age);
      end
    end
  end

  // once locked, sync must land where the free-running count wraps (R2)
  p_sync_on_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && frame_sync) |-> (pos_q == '0));
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter int NSTREAM = 4,
  parameter int NCHAN = 8,
  localparam int SW = $clog2(NSTREAM),
  localparam int CW = $clog2(NCHAN),
  localparam int SLOTW = SW + CW,
  localparam int SLOTS = NSTREAM * NCHAN
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [SLOTW-1:0]               waddr,
  input  logic [SLOTW-1:0]               wdata,
  input  logic [CW-1:0]                  rd_chan,
  output logic [NSTREAM-1:0][SLOTW-1:0]  rd_entry
);
  logic [SLOTW-1:0] map_q [SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) map_q[i] <= SLOTW'(i);
    end else if (we) begin
      map_q[waddr] <= wdata;
    end
  end

  for (genvar s = 0; s < NSTREAM; s++) begin : g_rd
    assign rd_entry[s] = map_q[{SW'(s), rd_chan}];
  end

  // a written entry holds the written value in the following cycle (R7)
  p_map_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (map_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
  import tsi_pkg::*;
#(
  parameter int NSTREAM = 4,
  parameter int NCHAN = 8,
  localparam int SW = $clog2(NSTREAM),
  localparam int CW = $clog2(NCHAN),
  localparam int SLOTW = SW + CW
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  bank_t                         wr_bank,
  input  logic [CW-1:0]                 wr_chan,
  input  logic [NSTREAM-1:0][7:0]       wr_data,
  input  bank_t                         rd_bank,
  input  logic [NSTREAM-1:0][SLOTW-1:0] rd_src,
  output logic [NSTREAM-1:0][7:0]       rd_data
);
  logic [7:0] store_q [NBANK][NSTREAM][NCHAN];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int s = 0; s < NSTREAM; s++) store_q[wr_bank][s][wr_chan] <= wr_data[s];
    end
  end

  for (genvar s = 0; s < NSTREAM; s++) begin : g_rd
    logic [SW-1:0] src_stream;
    logic [CW-1:0] src_chan;
    assign src_stream = rd_src[s][SLOTW-1:CW];
    assign src_chan   = rd_src[s][CW-1:0];
    assign rd_data[s] = store_q[rd_bank][src_stream][src_chan];
  end

  // the frame being filled is never the frame being read (R4)
  p_no_collision_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (rd_bank != wr_bank));
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int NSTREAM = 4,
  parameter int NCHAN = 8,
  localparam int SW = $clog2(NSTREAM),
  localparam int CW = $clog2(NCHAN),
  localparam int SLOTW = SW + CW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_sync,
  input  logic [NSTREAM-1:0] ser_in,
  output logic [NSTREAM-1:0] ser_out,
  input  logic               map_we,
  input  logic [SLOTW-1:0]   map_addr,
  input  logic [SLOTW-1:0]   map_wdata
);
  logic                          active;
  logic [CW-1:0]                 cur_chan;
  logic [2:0]                    cur_bit;
  bank_t                         cur_bank;
  logic [1:0]                    cur_age;

  // events brought out for the assertions
  logic                          chan_end;    // last bit of a channel
  logic                          next_is_new; // next channel opens a frame
  logic                          load_valid;  // next channel has data two frames old
  logic [CW-1:0]                 next_chan;
  bank_t                         rd_bank;

  logic [NSTREAM-1:0][7:0]       rx_shift_q;
  logic [NSTREAM-1:0][7:0]       rx_byte;
  logic [NSTREAM-1:0][SLOTW-1:0] src_entry;
  logic [NSTREAM-1:0][7:0]       src_byte;
  logic [NSTREAM-1:0][7:0]       tx_q;

  tsi_frame_timer #(.NCHAN(NCHAN)) u_timer (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .active(active), .cur_chan(cur_chan), .cur_bit(cur_bit),
    .cur_bank(cur_bank), .cur_age(cur_age)
  );

  always_comb begin
    chan_end    = active && (cur_bit == 3'd7);
    next_is_new = &cur_chan;
    next_chan   = cur_chan + CW'(1);
    rd_bank     = read_bank(cur_bank, next_is_new);
    load_valid  = next_is_new ? (cur_age != 2'd0) : (cur_age == 2'd2);
  end

  for (genvar s = 0; s < NSTREAM; s++) begin : g_line
    assign rx_byte[s] = {rx_shift_q[s][6:0], ser_in[s]};
    assign ser_out[s] = tx_q[s][3'd7 - cur_bit];
  end

  tsi_conn_mem #(.NSTREAM(NSTREAM), .NCHAN(NCHAN)) u_map (
    .clk(clk), .rst_n(rst_n), .we(map_we), .waddr(map_addr), .wdata(map_wdata),
    .rd_chan(next_chan), .rd_entry(src_entry)
  );

  tsi_data_mem #(.NSTREAM(NSTREAM), .NCHAN(NCHAN)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(chan_end), .wr_bank(cur_bank),
    .wr_chan(cur_chan), .wr_data(rx_byte), .rd_bank(rd_bank),
    .rd_src(src_entry), .rd_data(src_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_shift_q <= '0;
      tx_q       <= '0;
    end else begin
      for (int s = 0; s < NSTREAM; s++) rx_shift_q[s] <= rx_byte[s];
      if (chan_end) begin
        for (int s = 0; s < NSTREAM; s++) tx_q[s] <= load_valid ? src_byte[s] : 8'h00;
      end
    end
  end

  // lines stay quiet until two whole frames have been stored (R1)
  p_silent_until_primed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_age != 2'd2) |-> (ser_out == '0));
endmodule

// File: tb/tsi_switch_test.sv
module tsi_switch_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSTREAM = 4;
  localparam int NCHAN = 8;
  localparam int CW = 3;
  localparam int SLOTW = 5;
  localparam int SLOTS = NSTREAM * NCHAN;
  localparam int FBITS = 8 * NCHAN;

  // {output slot, source slot}; each field is {stream[1:0], channel[2:0]}
  localparam logic [9:0] VEC [8] = '{
    {2'd0, 3'd0, 2'd3, 3'd7},
    {2'd1, 3'd2, 2'd2, 3'd5},
    {2'd2, 3'd7, 2'd0, 3'd0},
    {2'd3, 3'd4, 2'd1, 3'd1},
    {2'd0, 3'd5, 2'd3, 3'd3},
    {2'd1, 3'd6, 2'd0, 3'd6},
    {2'd2, 3'd1, 2'd3, 3'd0},
    {2'd3, 3'd0, 2'd2, 3'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_sync = 1'b0;
  logic [NSTREAM-1:0] ser_in = '0;
  logic [NSTREAM-1:0] ser_out;
  logic map_we = 1'b0;
  logic [SLOTW-1:0] map_addr = '0;
  logic [SLOTW-1:0] map_wdata = '0;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int fr = 0;
  int mdl_map [SLOTS];
  int map_old [SLOTS];
  int wq_addr [8];
  int wq_data [8];
  int wq_n = 0;
  logic [7:0] got [NSTREAM][NCHAN];

  always #(CLK_PERIOD / 2) clk = ~clk;

  tsi_switch #(.NSTREAM(NSTREAM), .NCHAN(NCHAN)) uut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .ser_in(ser_in),
    .ser_out(ser_out), .map_we(map_we), .map_addr(map_addr), .map_wdata(map_wdata)
  );

  function automatic logic [7:0] din(int f, int s, int c);
    return 8'((f * 53 + s * 29 + c * 7 + 17) ^ (c * 16));
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic queue_write(int out_slot, int src_slot);
    wq_addr[wq_n] = out_slot;
    wq_data[wq_n] = src_slot;
    wq_n++;
  endtask

  // one frame on the lines, then every output slot compared with the model
  task automatic run_frame(string lbl);
    for (int i = 0; i < SLOTS; i++) map_old[i] = mdl_map[i];
    for (int i = 0; i < wq_n; i++) mdl_map[wq_addr[i]] = wq_data[i];
    for (int p = 0; p < FBITS; p++) begin
      @(negedge clk);
      frame_sync = (p == 0);
      for (int s = 0; s < NSTREAM; s++) ser_in[s] = din(fr, s, p / 8)[7 - (p % 8)];
      map_we = 1'b0;
      if (p >= 2 && p - 2 < wq_n) begin
        map_we = 1'b1;
        map_addr = SLOTW'(wq_addr[p - 2]);
        map_wdata = SLOTW'(wq_data[p - 2]);
      end
      #1;
      for (int s = 0; s < NSTREAM; s++) got[s][p / 8][7 - (p % 8)] = ser_out[s];
    end
    for (int s = 0; s < NSTREAM; s++) begin
      for (int c = 0; c < NCHAN; c++) begin
        int src;
        logic [7:0] exp;
        src = (c == 0) ? map_old[s * NCHAN + c] : mdl_map[s * NCHAN + c];
        exp = (fr >= 2) ? din(fr - 2, src / NCHAN, src % NCHAN) : 8'h00;
        check(got[s][c] == exp, lbl,
              $sformatf("frame %0d out stream %0d chan %0d", fr, s, c), got[s][c], exp);
      end
    end
    wq_n = 0;
    fr++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    frame_sync = 1'b0;
    ser_in = '0;
    map_we = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      check(ser_out == '0, "R1", "output during reset", ser_out, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      ser_in = 4'hF;
      #1;
      check(ser_out == '0, "R1", "output before first sync", ser_out, 0);
    end
    for (int i = 0; i < SLOTS; i++) mdl_map[i] = i;
    fr = 0;
    wq_n = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 R2: first two frames silent, framing positions
    run_frame("R1 R2");
    run_frame("R1 R2");
    // R5 R4 R2: reset map is straight through, two frames late
    run_frame("R2 R4 R5");
    run_frame("R2 R4 R5");

    // table walk: one map rewrite per frame (R4 R7 R8)
    for (int v = 0; v < 8; v++) begin
      queue_write(int'(VEC[v][9:5]), int'(VEC[v][4:0]));
      run_frame("R4 R7 R8");
    end
    run_frame("R4 R8");
    run_frame("R4 R8");
    // R3: decode the table fields as stream/channel independently
    for (int v = 0; v < 8; v++) begin
      int os, oc, ss, sc;
      os = int'(VEC[v][9:8]);
      oc = int'(VEC[v][7:5]);
      ss = int'(VEC[v][4:3]);
      sc = int'(VEC[v][2:0]);
      check(got[os][oc] == din(fr - 3, ss, sc), "R3",
            $sformatf("vector %0d field decode", v), got[os][oc], din(fr - 3, ss, sc));
    end

    // R6: one source to three outputs
    queue_write(0 * NCHAN + 1, 1 * NCHAN + 4);
    queue_write(2 * NCHAN + 3, 1 * NCHAN + 4);
    queue_write(3 * NCHAN + 6, 1 * NCHAN + 4);
    run_frame("R6");
    run_frame("R6");
    run_frame("R6");
    check(got[0][1] == din(fr - 3, 1, 4), "R6", "broadcast copy a", got[0][1], din(fr - 3, 1, 4));
    check(got[2][3] == din(fr - 3, 1, 4), "R6", "broadcast copy b", got[2][3], din(fr - 3, 1, 4));
    check(got[3][6] == din(fr - 3, 1, 4), "R6", "broadcast copy c", got[3][6], din(fr - 3, 1, 4));

    // R7: channel 0 rewrite mid-frame keeps old source this frame, new next frame
    queue_write(1 * NCHAN + 0, 0 * NCHAN + 7);
    run_frame("R7");
    check(got[1][0] == din(fr - 3, 1, 0), "R7", "chan 0 before switch", got[1][0], din(fr - 3, 1, 0));
    run_frame("R7");
    check(got[1][0] == din(fr - 3, 0, 7), "R7", "chan 0 after switch", got[1][0], din(fr - 3, 0, 7));
    check(got[1][1] == din(fr - 3, 1, 1), "R7", "neighbour untouched", got[1][1], din(fr - 3, 1, 1));

    // reset in the middle of traffic: silence then straight-through map again
    do_reset();
    run_frame("R1 R5");
    run_frame("R1 R5");
    run_frame("R4 R5");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule